// File: doc/BRIEF.md
# GPIO Pad Controller with Shared Interrupt Lines

This block is a bank of general-purpose pads behind a 32-bit register port. The pads are arranged in groups of at most fifteen slots. Each group's populated pad count is fixed by a parameter. Every populated pad owns two configuration words. The first word carries the pad's synchronized input level, its output drive bit and a 4-bit selector that picks one of sixteen shared interrupt lines. The second word carries a trigger mode and an inversion field. Slots beyond a group's pad count are unpopulated: they read as zero and ignore writes.

Each pad input passes through a synchronizer. It is then optionally inverted and fed to a trigger detector. The detector supports falling edge, rising edge, both edges and level. A firing trigger sets the status bit of the line the pad selects. Status bits are cleared by writing ones. An enable mask gates the status bits, and the gated bits are combined into a single registered interrupt output. Software normally sets the line selector and trigger mode of a pad, then enables the line in the mask. It services the interrupt by reading the status word and writing back the bits it has handled.

Top module: `gpc_pad_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `pad_out` is all zero, so all lines are masked and all triggers are disabled.
- R2: Pad p (p = 15*group + slot) has configuration word A at byte address 0x4400 + 1024*group + 8*slot and word B at that address + 4. In word A, bits 31:28 are the interrupt line selector and bit 1 is the output drive. Bit 1 appears on `pad_out[p]` in the cycle after the write. All other bits of word A read 0, except bit 0 (R3).
- R3: Bit 0 of word A is read-only and returns the pad input after a two-flop synchronizer. An input change made just before a clock edge is not visible to a read issued at that edge. It is visible to a read issued three edges later.
- R4: Word B bits 2:0 select the trigger: 0 off, 1 falling edge, 2 rising edge, 3 both edges, 4 level (high). Codes 5 to 7 never trigger. Edges are found by comparing the synchronized, inverted input with its value one cycle earlier.
- R5: Word B bits 7:4 are stored and read back. Bit 6 inverts the synchronized input before trigger detection, so level mode with bit 6 set triggers while the pad is low.
- R6: A firing trigger sets bit n of the status word, where n is the pad's line selector.
- R7: The status word at 0x0300 (bits 15:0) is cleared bit by bit by writing ones. Zero bits leave status unchanged. A trigger in the same cycle as a clear wins, so a level trigger that is still asserted keeps its bit set.
- R8: The mask word at 0x0380 (bits 15:0) is read/write. `irq` is registered and equals the OR over all lines of (status AND mask) one cycle earlier.
- R9: Unpopulated pad slots and reserved offsets read zero and ignore writes. Input changes on unpopulated pads never set status.
- R10: An access with a nonzero address bits 1:0, or at or beyond 0x4400 + 1024*NUM_GROUPS, is rejected. `rsp_err` is 1, `rsp_rdata` is 0, and a rejected write changes nothing.
- R11: Every request gets exactly one response: `rsp_valid` is high in the cycle after `req_valid` and carries the read data (zero for writes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read data, zero for writes and rejects |
| pad_in | input | NUM_GROUPS*15 | Raw pad input levels, one per slot |
| pad_out | output | NUM_GROUPS*15 | Pad output drive values, zero on unpopulated slots |
| irq | output | 1 | Combined masked interrupt |

## Verification
Bad trigger or synchronizer state shows up first as an `irq` or status change in the wrong cycle. The bench's per-cycle reference catches a timing slip of even one edge on the next clock. A wrong selector or decode shows up as a status bit on the wrong line, or as read data at the wrong address, on the next read of that word. A stuck status or mask bit shows up on `irq` one cycle after the stimulus that should have moved it. Unpopulated slots are probed through both read-back and status, so a leaking write or input is seen within one access.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
   localparam int LINE_W        = 4;
   localparam int NUM_LINES     = 1 << LINE_W;
   localparam int SLOTS_PER_GRP = 15;
   localparam int STATUS_OFS    = 32'h0000_0300;
   localparam int MASK_OFS      = 32'h0000_0380;
   localparam int PAD_BASE      = 32'h0000_4400;
   localparam int GRP_STRIDE    = 1024;

   typedef enum logic [2:0] {
      TM_OFF   = 3'd0,
      TM_FALL  = 3'd1,
      TM_RISE  = 3'd2,
      TM_BOTH  = 3'd3,
      TM_LEVEL = 3'd4
   } trig_mode_e;

   typedef enum logic [2:0] {
      AK_RSVD,
      AK_STATUS,
      AK_MASK,
      AK_CFGA,
      AK_CFGB,
      AK_BAD
   } acc_kind_e;

   typedef struct packed {
      logic [LINE_W-1:0] line;
      logic              drv;
      logic [2:0]        mode;
      logic [3:0]        inv;
   } pad_cfg_t;
endpackage

// File: rtl/gpc_addr_dec.sv
module gpc_addr_dec
   import gpc_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int NUM_GROUPS = 2,
   parameter logic [NUM_GROUPS*4-1:0] GROUP_PADS = 8'h58,
   parameter int SLOT_W     = 5
) (
   input  logic [ADDR_W-1:0] addr_i,
   output acc_kind_e         kind_o,
   output logic [SLOT_W-1:0] slot_o
);
   localparam int WIN_END = PAD_BASE + GRP_STRIDE * NUM_GROUPS;
   localparam int GRP_W   = ADDR_W - 10;

   logic [ADDR_W-1:0] off;
   logic [GRP_W-1:0]  grp;
   logic [6:0]        pos;
   logic [3:0]        cnt;
   logic [1:0]        unused_low;

   assign off        = addr_i - ADDR_W'(PAD_BASE);
   assign grp        = off[ADDR_W-1:10];
   assign pos        = off[9:3];
   assign unused_low = off[1:0];

   always_comb begin
      cnt = 4'd0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (int'(grp) == g) cnt = GROUP_PADS[g*4 +: 4];
      end
   end

   always_comb begin
      kind_o = AK_RSVD;
      slot_o = '0;
      if (addr_i[1:0] != 2'b00 || 32'(addr_i) >= WIN_END) begin
         kind_o = AK_BAD;
      end else if (32'(addr_i) == STATUS_OFS) begin
         kind_o = AK_STATUS;
      end else if (32'(addr_i) == MASK_OFS) begin
         kind_o = AK_MASK;
      end else if (32'(addr_i) >= PAD_BASE && int'(pos) < SLOTS_PER_GRP
                   && int'(pos) < int'(cnt)) begin
         kind_o = off[2] ? AK_CFGB : AK_CFGA;
         slot_o = SLOT_W'(int'(grp) * SLOTS_PER_GRP + int'(pos));
      end
   end
endmodule

// File: rtl/gpc_pad.sv
module gpc_pad
   import gpc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pad_i,
   input  logic              wr_a_i,
   input  logic              wr_b_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rd_a_o,
   output logic [31:0]       rd_b_o,
   output logic              pad_o,
   output logic              trig_o,
   output logic [LINE_W-1:0] line_o
);
   pad_cfg_t                 cfg_q;
   logic [SYNC_STAGES-1:0]   sync_q;
   logic                     rx;
   logic                     prev_q;
   logic                     unused_wd;

   assign unused_wd = ^{wdata_i[27:8], wdata_i[3]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         if (wr_a_i) begin
            cfg_q.line <= wdata_i[31:28];
            cfg_q.drv  <= wdata_i[1];
         end
         if (wr_b_i) begin
            cfg_q.mode <= wdata_i[2:0];
            cfg_q.inv  <= wdata_i[7:4];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pad_i};
         prev_q <= rx;
      end
   end

   assign rx = sync_q[SYNC_STAGES-1] ^ cfg_q.inv[2];

   always_comb begin
      case (trig_mode_e'(cfg_q.mode))
         TM_FALL:  trig_o = prev_q & ~rx;
         TM_RISE:  trig_o = ~prev_q & rx;
         TM_BOTH:  trig_o = prev_q ^ rx;
         TM_LEVEL: trig_o = rx;
         default:  trig_o = 1'b0;
      endcase
   end

   assign line_o = cfg_q.line;
   assign pad_o  = cfg_q.drv;
   assign rd_a_o = {cfg_q.line, 26'd0, cfg_q.drv, sync_q[SYNC_STAGES-1]};
   assign rd_b_o = {24'd0, cfg_q.inv, 1'b0, cfg_q.mode};
endmodule

// File: rtl/gpc_irq_agg.sv
module gpc_irq_agg
   import gpc_pkg::*;
#(
   parameter int SLOTS = 30
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [SLOTS-1:0]        trig_i,
   input  logic [SLOTS*LINE_W-1:0] line_i,
   input  logic                    clr_we_i,
   input  logic                    mask_we_i,
   input  logic [NUM_LINES-1:0]    wdata_i,
   output logic [NUM_LINES-1:0]    set_o,
   output logic [NUM_LINES-1:0]    status_o,
   output logic [NUM_LINES-1:0]    mask_o,
   output logic                    irq_o
);
   logic [NUM_LINES-1:0] clr;

   always_comb begin
      set_o = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (trig_i[i]) set_o[line_i[i*LINE_W +: LINE_W]] = 1'b1;
      end
   end

   assign clr = clr_we_i ? wdata_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_o <= '0;
         mask_o   <= '0;
         irq_o    <= 1'b0;
      end else begin
         status_o <= (status_o & ~clr) | set_o;
         irq_o    <= |(status_o & mask_o);
         if (mask_we_i) mask_o <= wdata_i;
      end
   end
endmodule

// File: rtl/gpc_pad_ctrl.sv
module gpc_pad_ctrl
   import gpc_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int NUM_GROUPS  = 2,
   parameter logic [NUM_GROUPS*4-1:0] GROUP_PADS = 8'h58,
   parameter int SYNC_STAGES = 2,
   localparam int SLOTS      = NUM_GROUPS * SLOTS_PER_GRP,
   localparam int SLOT_W     = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata,
   input  logic [SLOTS-1:0]  pad_in,
   output logic [SLOTS-1:0]  pad_out,
   output logic              irq
);
   if (NUM_GROUPS < 1 || NUM_GROUPS > 16) begin : g_bad_groups
      $error("NUM_GROUPS out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (longint'(PAD_BASE) + longint'(GRP_STRIDE) * NUM_GROUPS > (longint'(1) << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the pad window");
   end
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk_cnt
      if (GROUP_PADS[g*4 +: 4] == 4'd0 || GROUP_PADS[g*4 +: 4] == 4'd15 + 4'd1) begin : g_bad
         $error("group pad count must be 1..15");
      end
   end

   acc_kind_e               kind;
   logic [SLOT_W-1:0]       slot;
   logic                    wr_ok;
   logic [31:0]             rd_a [SLOTS];
   logic [31:0]             rd_b [SLOTS];
   logic [SLOTS-1:0]        trig;
   logic [SLOTS*LINE_W-1:0] lines;
   logic [NUM_LINES-1:0]    set_vec;
   logic [NUM_LINES-1:0]    status_q;
   logic [NUM_LINES-1:0]    mask_q;
   logic [31:0]             rd_mux;
   logic [15:0]             unused_wd_hi;

   assign unused_wd_hi = req_wdata[31:16];

   gpc_addr_dec #(
      .ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS),
      .GROUP_PADS(GROUP_PADS), .SLOT_W(SLOT_W)
   ) u_dec (
      .addr_i(req_addr), .kind_o(kind), .slot_o(slot)
   );

   assign wr_ok = req_valid & req_write & (kind != AK_BAD);

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      localparam int GRP = i / SLOTS_PER_GRP;
      localparam int POS = i % SLOTS_PER_GRP;
      if (POS < int'(GROUP_PADS[GRP*4 +: 4])) begin : g_pad
         logic wa, wb;
         assign wa = wr_ok && kind == AK_CFGA && int'(slot) == i;
         assign wb = wr_ok && kind == AK_CFGB && int'(slot) == i;
         gpc_pad #(.SYNC_STAGES(SYNC_STAGES)) u_pad (
            .clk(clk), .rst_n(rst_n), .pad_i(pad_in[i]),
            .wr_a_i(wa), .wr_b_i(wb), .wdata_i(req_wdata),
            .rd_a_o(rd_a[i]), .rd_b_o(rd_b[i]), .pad_o(pad_out[i]),
            .trig_o(trig[i]), .line_o(lines[i*LINE_W +: LINE_W])
         );
      end else begin : g_empty
         logic unused_in;
         assign unused_in = pad_in[i];
         assign rd_a[i]   = '0;
         assign rd_b[i]   = '0;
         assign pad_out[i] = 1'b0;
         assign trig[i]   = 1'b0;
         assign lines[i*LINE_W +: LINE_W] = '0;
      end
   end

   gpc_irq_agg #(.SLOTS(SLOTS)) u_agg (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .line_i(lines),
      .clr_we_i(wr_ok && kind == AK_STATUS),
      .mask_we_i(wr_ok && kind == AK_MASK),
      .wdata_i(req_wdata[NUM_LINES-1:0]),
      .set_o(set_vec), .status_o(status_q), .mask_o(mask_q), .irq_o(irq)
   );

   always_comb begin
      case (kind)
         AK_STATUS: rd_mux = {16'd0, status_q};
         AK_MASK:   rd_mux = {16'd0, mask_q};
         AK_CFGA:   rd_mux = rd_a[slot];
         AK_CFGB:   rd_mux = rd_b[slot];
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && kind == AK_BAD;
         rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/gpc_pad_ctrl_chk.sv
module gpc_pad_ctrl_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [31:0]       rsp_rdata,
   input logic              irq,
   input logic [15:0]       status_q,
   input logic [15:0]       mask_q,
   input logic [15:0]       set_vec
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> irq == $past(|(status_q & mask_q)));

   assert_one_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> rsp_valid == $past(req_valid));

   assert_no_spurious_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (status_q & ~$past(status_q) & ~$past(set_vec)) == 16'd0);

   assert_err_no_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_rdata == 32'd0);

   assert_misalign_rej_R10: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(req_valid && req_addr[1:0] != 2'b00) |-> rsp_err);
endmodule

bind gpc_pad_ctrl gpc_pad_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
   .irq(irq), .status_q(status_q), .mask_q(mask_q), .set_vec(set_vec)
);

// File: tb/gpc_pad_ctrl_bench.sv
module gpc_pad_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 30;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        req_valid = 0, req_write = 0;
   logic [15:0] req_addr = 0;
   logic [31:0] req_wdata = 0;
   logic        rsp_valid, rsp_err, irq;
   logic [31:0] rsp_rdata;
   logic [NS-1:0] pad_in = '0;
   logic [NS-1:0] pad_out;

   int total = 0, bad = 0;
   bit done = 0;

   gpc_pad_ctrl u_gpc_pad_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model: group 0 holds 8 pads, group 1 holds 5
   int cnt_of [2] = '{8, 5};
   bit        m_s1 [NS], m_s2 [NS], m_pv [NS], m_drv [NS];
   bit [3:0]  m_sel [NS], m_inv [NS];
   bit [2:0]  m_md [NS];
   bit [15:0] m_st, m_mk;
   bit        m_irq, m_rv, m_re;
   bit [31:0] m_rd;

   function automatic bit populated(int p);
      return (p % 15) < cnt_of[p / 15];
   endfunction

   // kind: 0 reserved, 1 status, 2 mask, 3 word A, 4 word B
   function automatic void decode(input bit [15:0] a, output int kind,
                                  output int p, output bit err);
      int off;
      kind = 0; p = 0;
      err = (a[1:0] != 0) || (int'(a) >= 32'h4400 + 2048);
      if (err) return;
      if (a == 16'h0300) kind = 1;
      else if (a == 16'h0380) kind = 2;
      else if (int'(a) >= 32'h4400) begin
         off = int'(a) - 32'h4400;
         if ((off % 1024) / 8 < 15 && (off % 1024) / 8 < cnt_of[off / 1024]) begin
            p = (off / 1024) * 15 + (off % 1024) / 8;
            kind = ((off / 4) % 2 == 1) ? 4 : 3;
         end
      end
   endfunction

   always @(posedge clk) begin
      int kind, p;
      bit err, iv, t;
      bit [15:0] setv, clr;
      bit npv [NS];
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin
            m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0; m_drv[i] = 0;
            m_sel[i] = 0; m_inv[i] = 0; m_md[i] = 0;
         end
         m_st = 0; m_mk = 0; m_irq = 0; m_rv = 0; m_re = 0; m_rd = 0;
      end else begin
         setv = 0;
         for (int i = 0; i < NS; i++) begin
            iv = m_s2[i] ^ m_inv[i][2];
            t = 0;
            if (populated(i)) begin
               if (m_md[i] == 1) t = m_pv[i] && !iv;
               else if (m_md[i] == 2) t = !m_pv[i] && iv;
               else if (m_md[i] == 3) t = m_pv[i] != iv;
               else if (m_md[i] == 4) t = iv;
            end
            if (t) setv[m_sel[i]] = 1;
            npv[i] = iv;
         end
         decode(req_addr, kind, p, err);
         m_rv = req_valid;
         m_re = req_valid && err;
         m_rd = 0;
         if (req_valid && !req_write && !err) begin
            if (kind == 1) m_rd = {16'd0, m_st};
            else if (kind == 2) m_rd = {16'd0, m_mk};
            else if (kind == 3) m_rd = {m_sel[p], 26'd0, m_drv[p], m_s2[p]};
            else if (kind == 4) m_rd = {24'd0, m_inv[p], 1'b0, m_md[p]};
         end
         m_irq = |(m_st & m_mk);
         clr = (req_valid && req_write && !err && kind == 1) ? req_wdata[15:0] : 16'd0;
         m_st = (m_st & ~clr) | setv;
         if (req_valid && req_write && !err) begin
            if (kind == 2) m_mk = req_wdata[15:0];
            if (kind == 3) begin m_sel[p] = req_wdata[31:28]; m_drv[p] = req_wdata[1]; end
            if (kind == 4) begin m_md[p] = req_wdata[2:0]; m_inv[p] = req_wdata[7:4]; end
         end
         for (int i = 0; i < NS; i++) begin
            m_pv[i] = npv[i]; m_s2[i] = m_s1[i]; m_s1[i] = pad_in[i];
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      logic [NS-1:0] po;
      if (rst_n && !done) begin
         for (int i = 0; i < NS; i++) po[i] = populated(i) && m_drv[i];
         chk("R11 rsp_valid", 32'(rsp_valid), 32'(m_rv));
         if (m_rv) begin
            chk("R10 rsp_err", 32'(rsp_err), 32'(m_re));
            chk("R11 rsp_rdata", rsp_rdata, m_rd);
         end
         chk("R8 irq", 32'(irq), 32'(m_irq));
         chk("R2 pad_out", 32'(pad_out), 32'(po));
      end
   end

   logic [31:0] rd_d;
   logic        rd_e, rd_v;

   task automatic access(input bit w, input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0; req_write = 0;
      rd_d = rsp_rdata; rd_e = rsp_err; rd_v = rsp_valid;
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      access(1, a, d);
   endtask

   task automatic rd(input logic [15:0] a);
      access(0, a, 0);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq", 32'(irq), 0);
      chk("R1 pad_out", 32'(pad_out), 0);
      rd(16'h0300); chk("R1 status", rd_d, 0);
      rd(16'h0380); chk("R1 mask", rd_d, 0);
      rd(16'h4804); chk("R1 wordB", rd_d, 0);

      // R2 field layout, bit0 read-only
      wr(16'h4410, 32'h5000_0003);
      rd(16'h4410); chk("R2 wordA readback", rd_d, 32'h5000_0002);
      chk("R2 drive on pad_out", 32'(pad_out), 32'h4);
      rd(16'h4414); chk("R2 wordB untouched", rd_d, 0);

      // R3 synchronizer latency
      @(negedge clk); pad_in[4] = 1;
      rd(16'h4420); chk("R3 not yet visible", rd_d, 0);
      idle(3);
      rd(16'h4420); chk("R3 input visible", rd_d, 1);

      // R4/R6 rising edge on pad 17 routed to line 3
      wr(16'h4810, 32'h3000_0000);
      wr(16'h0380, 32'h0008);
      wr(16'h4814, 32'h2);
      @(negedge clk); pad_in[17] = 1;
      idle(4);
      rd(16'h0300); chk("R4 R6 rising sets line 3", rd_d, 32'h8);
      chk("R8 irq asserted", 32'(irq), 1);
      wr(16'h0300, 32'h8);
      idle(2);
      rd(16'h0300); chk("R7 cleared by one", rd_d, 0);
      chk("R8 irq dropped", 32'(irq), 0);

      // R4 falling edge, R7 zero write, R8 masking
      wr(16'h4814, 32'h1);
      @(negedge clk); pad_in[17] = 0;
      idle(4);
      rd(16'h0300); chk("R4 falling", rd_d, 32'h8);
      wr(16'h0300, 32'h0);
      rd(16'h0300); chk("R7 zero write keeps", rd_d, 32'h8);
      wr(16'h0380, 32'h0);
      idle(2);
      chk("R8 masked irq low", 32'(irq), 0);
      wr(16'h0380, 32'h8);
      idle(2);
      chk("R8 unmasked irq high", 32'(irq), 1);
      wr(16'h0300, 32'h8);

      // R4 both edges
      wr(16'h4814, 32'h3);
      @(negedge clk); pad_in[17] = 1;
      idle(4);
      rd(16'h0300); chk("R4 both rise", rd_d, 32'h8);
      wr(16'h0300, 32'h8);
      @(negedge clk); pad_in[17] = 0;
      idle(4);
      rd(16'h0300); chk("R4 both fall", rd_d, 32'h8);
      wr(16'h0300, 32'h8);

      // R4 reserved mode code never triggers
      wr(16'h4814, 32'h5);
      @(negedge clk); pad_in[17] = 1;
      idle(4);
      @(negedge clk); pad_in[17] = 0;
      idle(4);
      rd(16'h0300); chk("R4 code 5 silent", rd_d, 0);
      rd(16'h4814); chk("R4 code readback", rd_d, 32'h5);

      // R5 inverted level on pad 0, line 7
      wr(16'h4400, 32'h7000_0000);
      wr(16'h4404, 32'h44);
      idle(3);
      rd(16'h0300); chk("R5 active-low level", rd_d, 32'h80);
      rd(16'h4404); chk("R5 inversion readback", rd_d, 32'h44);
      wr(16'h0300, 32'h80);
      rd(16'h0300); chk("R7 level holds over clear", rd_d, 32'h80);
      @(negedge clk); pad_in[0] = 1;
      idle(4);
      wr(16'h0300, 32'h80);
      rd(16'h0300); chk("R5 level released", rd_d, 0);

      // R9 unpopulated slot 10 and slot 29, reserved offset
      wr(16'h4450, 32'h1000_0002);
      wr(16'h4454, 32'h4);
      rd(16'h4450); chk("R9 empty slot reads 0", rd_d, 0);
      chk("R9 empty slot no drive", 32'(pad_out), 32'h4);
      @(negedge clk); pad_in[10] = 1;
      idle(4);
      rd(16'h0300); chk("R9 empty slot input ignored", rd_d, 0);
      rd(16'h4870); chk("R9 slot 29 reads 0", rd_d, 0);
      wr(16'h0100, 32'hFFFF_FFFF);
      rd(16'h0100); chk("R9 reserved offset", rd_d, 0);
      chk("R9 reserved no err", 32'(rd_e), 0);

      // R10 rejected accesses
      wr(16'h0382, 32'hFFFF);
      chk("R10 misaligned err", 32'(rd_e), 1);
      rd(16'h0380); chk("R10 mask unchanged", rd_d, 32'h8);
      rd(16'h4C00);
      chk("R10 out of window err", 32'(rd_e), 1);
      chk("R10 out of window data", rd_d, 0);

      // R11 response timing
      rd(16'h0380); chk("R11 rsp_valid after request", 32'(rd_v), 1);
      @(negedge clk); chk("R11 no rsp when idle", 32'(rsp_valid), 0);

      idle(2);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule